// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block is the controller side of a receive descriptor ring kept in shared packet memory. Every slot of the ring holds a buffer pointer, an ownership flag, a stored length and a truncation flag. Frames arrive as a byte stream with a last-byte marker and cannot be stalled. The block places each frame into the buffer of the slot at the ring head through a simple memory write port. When the frame ends it hands the slot to the processor and pulses a receive interrupt. It then moves to the next slot at once, without waiting for the processor.

Software works through a side port. A combinational read port shows any slot. A return port gives a slot a fresh buffer pointer and hands it back to the controller, both in one cycle. If the head slot still belongs to the processor when a frame starts, the ring is overrun. That frame is dropped whole, a saturating drop counter counts it, and an overrun flag is raised. Later frames are dropped in the same way until software returns the head slot.

Top module: `rx_ring_ctrl`

## Requirements
- R1: After reset every slot is owned by the processor (`cpu_rd_own` = 0), the head is slot 0, `drop_count`, `overrun`, `rx_irq` and `mem_we` are 0.
- R2: A return (`cpu_ret_valid` high for one cycle) stores `cpu_ret_ptr` in slot `cpu_ret_idx` and sets its ownership to the controller (`cpu_rd_own` = 1), both visible from the next cycle.
- R3: Byte k of an accepted frame (k counted from 0) is written with `mem_we` = 1 at address `ptr + k` of the head slot, in the cycle after the byte is presented.
- R4: In the cycle after the last byte, `rx_irq` is high for exactly one cycle, and the slot shows `cpu_rd_own` = 0 with `cpu_rd_len` equal to the number of bytes stored.
- R5: A frame longer than BUF_BYTES stores only its first BUF_BYTES bytes, with length BUF_BYTES and `cpu_rd_trunc` = 1. A frame of exactly BUF_BYTES bytes or fewer has `cpu_rd_trunc` = 0.
- R6: Consecutive frames fill successive slots in ring order, even back to back with no idle cycle and no processor action, and the head wraps from slot SLOTS-1 to slot 0.
- R7: A frame whose first byte arrives while the head slot is processor-owned is dropped whole: no memory write, no interrupt, no slot change, and `drop_count` rises by one, saturating at 2^CNT_W-1.
- R8: `overrun` rises on a dropped frame and falls on the next accepted frame. A return in the same cycle as a frame's first byte does not rescue that frame; the following frame is accepted.
- R9: A frame completion and a return to a different slot in the same cycle both take full effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | AW | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| rx_irq | output | 1 | One-cycle receive interrupt |
| overrun | output | 1 | Ring overrun flag |
| drop_count | output | CNT_W | Saturating count of dropped frames |
| cpu_rd_idx | input | log2(SLOTS) | Slot selected for reading |
| cpu_rd_own | output | 1 | 1 = controller owns slot, 0 = processor owns it |
| cpu_rd_ptr | output | AW | Buffer pointer of slot |
| cpu_rd_len | output | log2(BUF_BYTES+1) | Stored length of slot |
| cpu_rd_trunc | output | 1 | Frame in slot was cut to BUF_BYTES |
| cpu_ret_valid | input | 1 | Return a slot this cycle |
| cpu_ret_idx | input | log2(SLOTS) | Slot being returned |
| cpu_ret_ptr | input | AW | New buffer pointer for returned slot |

## Verification
Two pairs of events can land in the same clock edge. The first is completion of a frame into the head slot together with software returning a different slot. The bench returns slot 2 while it drives the last byte of a frame into slot 1, then checks that slot 1 holds the frame as processor-owned and slot 2 holds the new pointer as controller-owned. The second is a return of the head slot in the very cycle a frame starts during overrun. The bench judges it by the absence of memory writes and interrupts for that frame, and by acceptance of the next frame with `overrun` falling.

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl #(
  parameter int SLOTS     = 16,
  parameter int BUF_BYTES = 1524,
  parameter int AW        = 32,
  parameter int CNT_W     = 16,
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int LW = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [7:0]       mem_wdata,
  output logic             rx_irq,
  output logic             overrun,
  output logic [CNT_W-1:0] drop_count,
  input  logic [IW-1:0]    cpu_rd_idx,
  output logic             cpu_rd_own,
  output logic [AW-1:0]    cpu_rd_ptr,
  output logic [LW-1:0]    cpu_rd_len,
  output logic             cpu_rd_trunc,
  input  logic             cpu_ret_valid,
  input  logic [IW-1:0]    cpu_ret_idx,
  input  logic [AW-1:0]    cpu_ret_ptr
);
  localparam logic [CNT_W-1:0] MAXC = '1;
  localparam logic [LW-1:0]    CAP  = LW'(BUF_BYTES);
  localparam logic [IW-1:0]    LAST = IW'(SLOTS - 1);

  typedef enum logic [1:0] {IDLE, FILL, DROP} mode_t;
  mode_t mode;

  logic [SLOTS-1:0] own;
  logic [SLOTS-1:0] trunc;
  logic [AW-1:0]    ptr [SLOTS];
  logic [LW-1:0]    len [SLOTS];
  logic [IW-1:0]    head;
  logic [LW-1:0]    cnt;
  logic             cut;

  wire start = in_valid && (mode == IDLE);
  wire take  = start && own[head];
  wire drop  = start && !own[head];
  wire more  = in_valid && (mode == FILL);
  wire [LW-1:0] off = take ? '0 : cnt;
  wire room  = off < CAP;
  wire wr    = (take || more) && room;
  wire done  = (take || more) && in_last;
  wire [LW-1:0] cnt_nx = wr ? off + LW'(1) : off;
  wire cut_nx = (take ? 1'b0 : cut) | !room;

  assign cpu_rd_own   = own[cpu_rd_idx];
  assign cpu_rd_ptr   = ptr[cpu_rd_idx];
  assign cpu_rd_len   = len[cpu_rd_idx];
  assign cpu_rd_trunc = trunc[cpu_rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= IDLE;
      own        <= '0;
      trunc      <= '0;
      head       <= '0;
      cnt        <= '0;
      cut        <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rx_irq     <= 1'b0;
      overrun    <= 1'b0;
      drop_count <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        ptr[i] <= '0;
        len[i] <= '0;
      end
    end else begin
      mem_we    <= wr;
      mem_addr  <= ptr[head] + AW'(off);
      mem_wdata <= in_data;
      rx_irq    <= done;

      if (cpu_ret_valid) begin
        ptr[cpu_ret_idx] <= cpu_ret_ptr;
        own[cpu_ret_idx] <= 1'b1;
      end

      if (take || more) begin
        cnt <= cnt_nx;
        cut <= cut_nx;
      end
      if (take) overrun <= 1'b0;

      if (done) begin
        len[head]   <= cnt_nx;
        trunc[head] <= cut_nx;
        own[head]   <= 1'b0;
        head        <= (head == LAST) ? '0 : head + IW'(1);
        mode        <= IDLE;
      end else if (take) begin
        mode <= FILL;
      end

      if (drop) begin
        overrun <= 1'b1;
        if (drop_count != MAXC) drop_count <= drop_count + CNT_W'(1);
        mode <= in_last ? IDLE : DROP;
      end

      if (mode == DROP && in_valid && in_last) mode <= IDLE;
    end
  end

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(in_valid && in_last)); // R4
  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == DROP) |=> !mem_we); // R7
  AST_DROP_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == MAXC) |=> (drop_count == MAXC)); // R7
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(head) |-> (head == (($past(head) == LAST) ? '0 : $past(head) + IW'(1)))); // R6
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_len <= CAP); // R5
  AST_OVERRUN_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun); // R8
endmodule

// File: tb/rx_ring_ctrl_test.sv
module rx_ring_ctrl_test;
  localparam int CLK_P = 10;
  localparam int SLOTS = 4;
  localparam int BUF   = 6;
  localparam int AW    = 16;
  localparam int CW    = 3;
  localparam int LW    = $clog2(BUF + 1);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0;
  logic [7:0] in_data = 0;
  logic mem_we, rx_irq, overrun;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [CW-1:0] drop_count;
  logic [1:0] cpu_rd_idx = 0, cpu_ret_idx = 0;
  logic cpu_rd_own, cpu_rd_trunc, cpu_ret_valid = 0;
  logic [AW-1:0] cpu_rd_ptr, cpu_ret_ptr = 0;
  logic [LW-1:0] cpu_rd_len;

  int n_chk = 0, n_fail = 0, wcount = 0, irq_cnt = 0;
  logic [7:0] m [0:1023];

  always #(CLK_P/2) clk = ~clk;

  rx_ring_ctrl #(.SLOTS(SLOTS), .BUF_BYTES(BUF), .AW(AW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rx_irq(rx_irq),
    .overrun(overrun), .drop_count(drop_count), .cpu_rd_idx(cpu_rd_idx),
    .cpu_rd_own(cpu_rd_own), .cpu_rd_ptr(cpu_rd_ptr), .cpu_rd_len(cpu_rd_len),
    .cpu_rd_trunc(cpu_rd_trunc), .cpu_ret_valid(cpu_ret_valid),
    .cpu_ret_idx(cpu_ret_idx), .cpu_ret_ptr(cpu_ret_ptr));

  always @(posedge clk) begin
    if (rst_n && mem_we) begin
      m[mem_addr[9:0]] <= mem_wdata;
      wcount <= wcount + 1;
    end
    if (rst_n && rx_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int seed, input int b);
    return 8'(seed * 16 + b);
  endfunction

  task automatic give(input int idx, input int p);
    @(negedge clk);
    cpu_ret_valid = 1; cpu_ret_idx = 2'(idx); cpu_ret_ptr = AW'(p);
    @(negedge clk);
    cpu_ret_valid = 0;
  endtask

  task automatic frame(input int len, input int seed, input bit exp_irq,
                       input int ret_at, input int ret_idx, input int ret_ptr);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      in_valid = 1; in_data = bval(seed, b); in_last = (b == len - 1);
      cpu_ret_valid = (b == ret_at);
      cpu_ret_idx = 2'(ret_idx); cpu_ret_ptr = AW'(ret_ptr);
    end
    @(negedge clk);
    check(rx_irq == exp_irq, "R4 irq after last byte", int'(rx_irq), int'(exp_irq));
    in_valid = 0; in_last = 0; cpu_ret_valid = 0;
    @(negedge clk);
    check(rx_irq == 0, "R4 irq single cycle", int'(rx_irq), 0);
  endtask

  task automatic slot_ok(input int idx, input int p, input int len, input int seed);
    int st;
    st = (len < BUF) ? len : BUF;
    cpu_rd_idx = 2'(idx); #1;
    check(cpu_rd_own == 0, "R4 slot handed to processor", int'(cpu_rd_own), 0);
    check(int'(cpu_rd_len) == st, "R4 R5 stored length", int'(cpu_rd_len), st);
    check(int'(cpu_rd_trunc) == int'(len > BUF), "R5 trunc flag", int'(cpu_rd_trunc), int'(len > BUF));
    check(int'(cpu_rd_ptr) == p, "R2 pointer kept", int'(cpu_rd_ptr), p);
    for (int b = 0; b < st; b++)
      check(m[p + b] == bval(seed, b), "R3 byte in buffer", int'(m[p + b]), int'(bval(seed, b)));
    if (len > BUF) check(m[p + BUF] == 8'hAA, "R5 nothing past buffer", int'(m[p + BUF]), 'hAA);
  endtask

  initial begin
    int w0, i0, lens[4];
    for (int i = 0; i < 1024; i++) m[i] = 8'hAA;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!mem_we && !rx_irq && !overrun && drop_count == 0, "R1 reset outputs",
          int'({mem_we, rx_irq, overrun, drop_count}), 0);
    for (int i = 0; i < SLOTS; i++) begin
      cpu_rd_idx = 2'(i); #1;
      check(cpu_rd_own == 0, "R1 slot processor-owned", int'(cpu_rd_own), 0);
    end

    for (int i = 0; i < SLOTS; i++) give(i, 'h100 + i * 'h20);
    for (int i = 0; i < SLOTS; i++) begin
      cpu_rd_idx = 2'(i); #1;
      check(cpu_rd_own == 1, "R2 return owns slot", int'(cpu_rd_own), 1);
      check(int'(cpu_rd_ptr) == 'h100 + i * 'h20, "R2 return pointer", int'(cpu_rd_ptr), 'h100 + i * 'h20);
    end

    lens = '{3, 1, 6, 9};
    w0 = wcount;
    for (int i = 0; i < SLOTS; i++) frame(lens[i], i + 1, 1, -1, 0, 0);
    check(wcount - w0 == 16, "R3 R5 write count", wcount - w0, 16);
    for (int i = 0; i < SLOTS; i++) slot_ok(i, 'h100 + i * 'h20, lens[i], i + 1);

    w0 = wcount; i0 = irq_cnt;
    frame(4, 9, 0, -1, 0, 0);
    check(wcount == w0 && irq_cnt == i0, "R7 dropped frame silent", wcount - w0, 0);
    check(drop_count == 1, "R7 drop count", int'(drop_count), 1);
    check(overrun == 1, "R8 overrun raised", int'(overrun), 1);
    slot_ok(0, 'h100, 3, 1);
    for (int k = 2; k <= 9; k++) begin
      frame(2, 5, 0, -1, 0, 0);
      check(int'(drop_count) == ((k < 7) ? k : 7), "R7 saturating count", int'(drop_count), (k < 7) ? k : 7);
    end

    w0 = wcount;
    frame(2, 6, 0, 0, 0, 'h200);
    check(wcount == w0, "R8 same-cycle return not rescuing", wcount - w0, 0);
    check(overrun == 1, "R8 overrun held", int'(overrun), 1);
    cpu_rd_idx = 0; #1;
    check(cpu_rd_own == 1, "R8 return took effect", int'(cpu_rd_own), 1);
    frame(4, 7, 1, -1, 0, 0);
    check(overrun == 0, "R8 overrun cleared", int'(overrun), 0);
    slot_ok(0, 'h200, 4, 7);

    give(1, 'h240);
    frame(5, 8, 1, 4, 2, 'h280);
    slot_ok(1, 'h240, 5, 8);
    cpu_rd_idx = 2; #1;
    check(cpu_rd_own == 1 && int'(cpu_rd_ptr) == 'h280, "R9 coincident return", int'(cpu_rd_ptr), 'h280);
    frame(2, 3, 1, -1, 0, 0);
    slot_ok(2, 'h280, 2, 3);

    give(3, 'h2C0); give(0, 'h300);
    i0 = irq_cnt;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      in_valid = 1; in_data = (b < 2) ? bval(4, b) : bval(2, b - 2); in_last = (b == 1) || (b == 3);
    end
    @(negedge clk); in_valid = 0; in_last = 0;
    @(negedge clk);
    check(irq_cnt - i0 == 2, "R6 back-to-back interrupts", irq_cnt - i0, 2);
    slot_ok(3, 'h2C0, 2, 4);
    slot_ok(0, 'h300, 2, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule